// File: doc/BRIEF.md
# Out-of-Order Issue and Wakeup Engine

This block schedules decoded instructions out of program order using register renaming through producer tags. It holds eight stations in three classes: three load buffers, three add/subtract stations and two multiply/divide stations. A status table records, for each of 16 registers, which station will produce its next value. Instructions arrive one per cycle in program order. A source whose producer is still pending records that producer's tag, and a source that is available records its value. The destination's table entry takes the new station's tag, which removes write-after-read and write-after-write hazards.

A station whose operands are all present counts down a fixed latency. It then waits for a single shared result bus. Every bus transfer carries the producing station's tag and a 32-bit value. Waiting stations take their operands from the bus, and the register file is updated only when the register still names that producer. The memory word a load returns is supplied with the load itself. Arithmetic is modelled on 32-bit integers.

Top module: `tomasulo_core`

## Requirements
- R1: After reset, all stations are free, every register holds 0 with no pending producer, no broadcast is driven, and `in_ready` is high for every operation.
- R2: Opcode encoding is 0 load, 1 add, 2 subtract, 3 multiply, 4 divide. Loads use load buffers, add/subtract use adder stations, and multiply/divide use multiplier stations. `in_ready` is low while every station of the presented operation's class is busy. An instruction is accepted only when `in_valid` and `in_ready` are both high, and at most one is accepted per cycle.
- R3: Station tags are 1..3 for load buffers, 4..6 for adder stations and 7..8 for multiplier stations. The lowest free tag of the class is chosen. From the cycle after issue, the destination register reports that tag as its producer.
- R4: A load accepted in cycle c broadcasts its supplied memory word in cycle c+3.
- R5: With both operands available at issue in cycle c, add and subtract broadcast in c+3, multiply in c+11 and divide in c+41.
- R6: A station whose last operand arrives on a broadcast in cycle N starts counting in N+1. It broadcasts in N+3 for add/subtract, N+11 for multiply and N+41 for divide.
- R7: A later writer replaces the producer tag of its destination. When an earlier producer broadcasts after that, the register's value and tag are left unchanged.
- R8: On a broadcast, a register whose producer tag equals the broadcast tag takes the value, and its tag is cleared in the next cycle.
- R9: When several stations are ready to broadcast in the same cycle, the lowest tag wins. The others hold their results and try again in the following cycles.
- R10: Subtract wraps modulo 2^32, multiply returns the low 32 bits of the product, and division by zero returns all ones.
- R11: A station is busy during the cycle it broadcasts and can be reused from the next cycle.
- R12: An instruction accepted in the same cycle that its source's producer broadcasts takes the broadcast value directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction presented |
| in_op | input | 3 | Operation code |
| in_dst | input | 4 | Destination register |
| in_src_j | input | 4 | First source register |
| in_src_k | input | 4 | Second source register |
| in_mem_word | input | 32 | Memory word returned for a load |
| in_ready | output | 1 | A station of the needed class is free |
| cdb_valid | output | 1 | Result broadcast this cycle |
| cdb_tag | output | 4 | Tag of the broadcasting station |
| cdb_value | output | 32 | Broadcast result |
| dbg_reg | input | 4 | Register selected for observation |
| dbg_tag | output | 4 | Pending producer tag of the selected register, 0 if none |
| dbg_value | output | 32 | Value of the selected register |

## Verification
The bench builds the block with its defaults: three load buffers, three adder stations, two multiplier stations, and latencies of 2, 2, 10 and 40. With only two multiplier stations, two multiplies fill the class and a stall is easy to reach. Three loads in a row fill the load buffers while the first is still broadcasting, so the same stimulus exercises reuse of a freed station. Two adder stations woken by one load finish together with a later load, which makes a three-way bus contention reachable. The long divide latency keeps a station busy while later writers rename its register.

// File: rtl/tomasulo_pkg.sv
package tomasulo_pkg;

    typedef enum logic [2:0] {
        OP_LD  = 3'd0,
        OP_ADD = 3'd1,
        OP_SUB = 3'd2,
        OP_MUL = 3'd3,
        OP_DIV = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CL_MEM = 2'd0,
        CL_ADD = 2'd1,
        CL_MUL = 2'd2
    } class_e;

    function automatic class_e op_class(op_e op);
        case (op)
            OP_LD:          return CL_MEM;
            OP_MUL, OP_DIV: return CL_MUL;
            default:        return CL_ADD;
        endcase
    endfunction

endpackage

// File: rtl/ts_pick.sv
// Lowest-index picker, used for station allocation and for bus arbitration.
module ts_pick #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx,
    output logic [N-1:0] grant
);
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any      = 1'b1;
                idx      = W'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ts_exec.sv
// Result of the station that owns the bus this cycle.
module ts_exec
    import tomasulo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_e             op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = a * b;
            OP_DIV:  y = (b == '0) ? '1 : a / b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/tomasulo_core.sv
module tomasulo_core
    import tomasulo_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NREG    = 16,
    parameter int NLD     = 3,
    parameter int NADD    = 3,
    parameter int NMUL    = 2,
    parameter int LAT_LD  = 2,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [2:0]                     in_op,
    input  logic [$clog2(NREG)-1:0]        in_dst,
    input  logic [$clog2(NREG)-1:0]        in_src_j,
    input  logic [$clog2(NREG)-1:0]        in_src_k,
    input  logic [XLEN-1:0]                in_mem_word,
    output logic                           in_ready,
    output logic                           cdb_valid,
    output logic [$clog2(NLD+NADD+NMUL+1)-1:0] cdb_tag,
    output logic [XLEN-1:0]                cdb_value,
    input  logic [$clog2(NREG)-1:0]        dbg_reg,
    output logic [$clog2(NLD+NADD+NMUL+1)-1:0] dbg_tag,
    output logic [XLEN-1:0]                dbg_value
);
    localparam int NST     = NLD + NADD + NMUL;
    localparam int TAG_W   = $clog2(NST + 1);
    localparam int SLOT_W  = (NST > 1) ? $clog2(NST) : 1;
    localparam int LAT_M1  = (LAT_LD > LAT_ADD) ? LAT_LD : LAT_ADD;
    localparam int LAT_M2  = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
    localparam int LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        op_e              op;
        logic [XLEN-1:0]  vj;
        logic [XLEN-1:0]  vk;
        logic [TAG_W-1:0] qj;
        logic [TAG_W-1:0] qk;
        logic [CNT_W-1:0] cnt;
    } stn_t;

    typedef struct packed {
        stn_t [NST-1:0]                st;
        logic [NREG-1:0][XLEN-1:0]     rf;
        logic [NREG-1:0][TAG_W-1:0]    rs;
    } core_t;

    core_t q, d;

    function automatic logic [CNT_W-1:0] lat_of(op_e op);
        case (op)
            OP_LD:   return CNT_W'(LAT_LD);
            OP_MUL:  return CNT_W'(LAT_MUL);
            OP_DIV:  return CNT_W'(LAT_DIV);
            default: return CNT_W'(LAT_ADD);
        endcase
    endfunction

    // ---------------- class masks and station vectors ----------------
    logic [NST-1:0] m_mem, m_add, m_mul, busy_v, done_v;
    for (genvar g = 0; g < NST; g++) begin : g_cls
        assign m_mem[g]  = (g < NLD);
        assign m_add[g]  = (g >= NLD) && (g < NLD + NADD);
        assign m_mul[g]  = (g >= NLD + NADD);
        assign busy_v[g] = q.st[g].busy;
        assign done_v[g] = q.st[g].done;
    end

    op_e            cur_op;
    logic [NST-1:0] free_req;
    assign cur_op = op_e'(in_op);

    always_comb begin
        case (op_class(cur_op))
            CL_MEM:  free_req = ~busy_v & m_mem;
            CL_MUL:  free_req = ~busy_v & m_mul;
            default: free_req = ~busy_v & m_add;
        endcase
    end

    // ---------------- allocation and bus arbitration ----------------
    logic              slot_ok, bc_any, fire;
    logic [SLOT_W-1:0] slot_idx, bc_idx;
    logic [NST-1:0]    slot_oh, bc_oh;
    logic [TAG_W-1:0]  new_tag, bc_tag;
    logic [XLEN-1:0]   bc_val;

    ts_pick #(.N(NST), .W(SLOT_W)) u_alloc (
        .req(free_req), .any(slot_ok), .idx(slot_idx), .grant(slot_oh)
    );

    ts_pick #(.N(NST), .W(SLOT_W)) u_arb (
        .req(done_v), .any(bc_any), .idx(bc_idx), .grant(bc_oh)
    );

    ts_exec #(.XLEN(XLEN)) u_exec (
        .op(q.st[bc_idx].op), .a(q.st[bc_idx].vj), .b(q.st[bc_idx].vk), .y(bc_val)
    );

    assign fire    = in_valid && slot_ok;
    assign new_tag = TAG_W'(slot_idx) + TAG_W'(1);
    assign bc_tag  = TAG_W'(bc_idx) + TAG_W'(1);

    // ---------------- next state ----------------
    stn_t new_st;

    always_comb begin
        // operand capture at issue, with same-cycle forwarding from the bus
        new_st      = '0;
        new_st.busy = 1'b1;
        new_st.op   = cur_op;
        new_st.cnt  = lat_of(cur_op);
        if (cur_op == OP_LD) begin
            new_st.vj = in_mem_word;
        end else begin
            if (q.rs[in_src_j] == '0) begin
                new_st.vj = q.rf[in_src_j];
            end else if (bc_any && q.rs[in_src_j] == bc_tag) begin
                new_st.vj = bc_val;
            end else begin
                new_st.qj = q.rs[in_src_j];
            end
            if (q.rs[in_src_k] == '0) begin
                new_st.vk = q.rf[in_src_k];
            end else if (bc_any && q.rs[in_src_k] == bc_tag) begin
                new_st.vk = bc_val;
            end else begin
                new_st.qk = q.rs[in_src_k];
            end
        end

        d = q;

        for (int i = 0; i < NST; i++) begin
            if (q.st[i].busy) begin
                if (!q.st[i].done && q.st[i].qj == '0 && q.st[i].qk == '0) begin
                    if (q.st[i].cnt <= CNT_W'(1)) begin
                        d.st[i].done = 1'b1;
                        d.st[i].cnt  = '0;
                    end else begin
                        d.st[i].cnt = q.st[i].cnt - CNT_W'(1);
                    end
                end
                if (bc_any && q.st[i].qj == bc_tag) begin
                    d.st[i].vj = bc_val;
                    d.st[i].qj = '0;
                end
                if (bc_any && q.st[i].qk == bc_tag) begin
                    d.st[i].vk = bc_val;
                    d.st[i].qk = '0;
                end
            end
            if (bc_oh[i]) begin
                d.st[i] = '0;
            end
        end

        for (int r = 0; r < NREG; r++) begin
            if (bc_any && q.rs[r] == bc_tag) begin
                d.rf[r] = bc_val;
                d.rs[r] = '0;
            end
        end

        if (fire) begin
            for (int i = 0; i < NST; i++) begin
                if (slot_oh[i]) begin
                    d.st[i] = new_st;
                end
            end
            d.rs[in_dst] = new_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // ---------------- outputs ----------------
    assign in_ready  = slot_ok;
    assign cdb_valid = bc_any;
    assign cdb_tag   = bc_tag;
    assign cdb_value = bc_val;
    assign dbg_tag   = q.rs[dbg_reg];
    assign dbg_value = q.rf[dbg_reg];

    // ---------------- assertions ----------------
    a_r3_rename_tag: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> q.rs[$past(in_dst)] == $past(new_tag));

    for (genvar g = 0; g < NST; g++) begin : g_chk_st
        a_r11_free_after_bcast: assert property (@(posedge clk) disable iff (!rst_n)
            bc_oh[g] |=> !q.st[g].busy);

        a_r6_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
            (q.st[g].busy && (q.st[g].qj != '0 || q.st[g].qk != '0))
                |=> q.st[g].cnt == $past(q.st[g].cnt));

        a_r9_loser_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
            (q.st[g].done && !bc_oh[g]) |=> q.st[g].done && q.st[g].busy);
    end

    for (genvar r = 0; r < NREG; r++) begin : g_chk_rf
        a_r8_status_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_any && q.rs[r] == bc_tag && !(fire && in_dst == ($clog2(NREG))'(r)))
                |=> q.rs[r] == '0 && q.rf[r] == $past(bc_val));
    end

endmodule

// File: tb/sim_tomasulo_core.sv
module sim_tomasulo_core;

    localparam int O_LD = 0, O_ADD = 1, O_SUB = 2, O_MUL = 3, O_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [3:0]  in_dst = '0, in_src_j = '0, in_src_k = '0, dbg_reg = '0;
    logic [31:0] in_mem_word = '0;
    logic        in_ready, cdb_valid;
    logic [3:0]  cdb_tag, dbg_tag;
    logic [31:0] cdb_value, dbg_value;

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    tomasulo_core u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src_j(in_src_j), .in_src_k(in_src_k),
        .in_mem_word(in_mem_word), .in_ready(in_ready), .cdb_valid(cdb_valid),
        .cdb_tag(cdb_tag), .cdb_value(cdb_value), .dbg_reg(dbg_reg),
        .dbg_tag(dbg_tag), .dbg_value(dbg_value)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // scoreboard of expected broadcasts
    typedef struct {
        int          tag;
        logic [31:0] val;
        int          at;
        string       req;
    } exp_t;
    exp_t sb[$];

    task automatic push(input int tag, input logic [31:0] val, input int at, input string req);
        exp_t e;
        e.tag = tag; e.val = val; e.at = at; e.req = req;
        sb.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        int hit;
        hit = -1;
        if (rst_n && cdb_valid) begin
            for (int i = 0; i < sb.size(); i++)
                if (hit < 0 && sb[i].tag == int'(cdb_tag)) hit = i;
            if (hit < 0) begin
                chk(1'b0, "R9", "unexpected broadcast tag", longint'(cdb_tag), 0);
            end else begin
                chk(cdb_value === sb[hit].val, sb[hit].req, "broadcast value",
                    longint'(cdb_value), longint'(sb[hit].val));
                chk(cyc == sb[hit].at, sb[hit].req, "broadcast cycle",
                    longint'(cyc), longint'(sb[hit].at));
                sb.delete(hit);
            end
        end
    end

    // driver
    task automatic issue(input int op, input int dst, input int sj, input int sk,
                         input logic [31:0] mem, output int c);
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'(op); in_dst = 4'(dst);
        in_src_j = 4'(sj); in_src_k = 4'(sk); in_mem_word = mem;
        #1;
        chk(in_ready === 1'b1, "R2", "ready at issue", longint'(in_ready), 1);
        c = cyc;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic probe(input int op, input bit exp, input string req);
        @(negedge clk);
        in_valid = 1'b0; in_op = 3'(op);
        #1;
        chk(in_ready === exp, req, "in_ready", longint'(in_ready), longint'(exp));
    endtask

    task automatic look(input int r, input int etag, input logic [31:0] eval, input string req);
        dbg_reg = 4'(r);
        #1;
        chk(dbg_tag === 4'(etag), req, $sformatf("tag of r%0d", r), longint'(dbg_tag), longint'(etag));
        chk(dbg_value === eval, req, $sformatf("value of r%0d", r), longint'(dbg_value), longint'(eval));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int c1, c2, c3, c4, c5, c6;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(cdb_valid === 1'b0, "R1", "no broadcast after reset", longint'(cdb_valid), 0);
        look(4, 0, 32'd0, "R1");
        look(15, 0, 32'd0, "R1");
        probe(O_LD, 1'b1, "R1");
        probe(O_ADD, 1'b1, "R1");
        probe(O_DIV, 1'b1, "R1");

        // preload, load latency, class exhaustion and reuse
        issue(O_LD, 4, 0, 0, 32'd5, c1);  push(1, 32'd5, c1 + 3, "R4");
        issue(O_LD, 5, 0, 0, 32'd7, c2);  push(2, 32'd7, c2 + 3, "R4");
        issue(O_LD, 9, 0, 0, 32'd0, c3);  push(3, 32'd0, c3 + 3, "R4");
        look(4, 1, 32'd0, "R3");
        look(9, 3, 32'd0, "R3");
        probe(O_LD, 1'b0, "R2");                 // all three buffers busy, first one broadcasting
        probe(O_ADD, 1'b1, "R2");
        issue(O_LD, 3, 0, 0, 32'd100, c4); push(1, 32'd100, c4 + 3, "R11");
        idle(8);
        look(4, 0, 32'd5, "R8");
        look(5, 0, 32'd7, "R8");
        look(3, 0, 32'd100, "R8");

        // dependency chain: wakeup, forwarding, renaming of r6
        issue(O_LD, 6, 0, 0, 32'd4, c1);    push(1, 32'd4, c1 + 3, "R4");
        issue(O_LD, 2, 0, 0, 32'd3, c2);    push(2, 32'd3, c1 + 4, "R4");
        issue(O_MUL, 0, 2, 4, 32'd0, c3);   push(7, 32'd15, c1 + 15, "R6");
        issue(O_SUB, 8, 6, 2, 32'd0, c4);   push(4, 32'd1, c1 + 7, "R12");
        issue(O_DIV, 10, 0, 6, 32'd0, c5);  push(8, 32'd3, c1 + 56, "R6");
        issue(O_ADD, 6, 8, 2, 32'd0, c6);   push(5, 32'd4, c1 + 10, "R6");
        look(6, 5, 32'd4, "R3");
        idle(60);
        look(0, 0, 32'd15, "R8");
        look(8, 0, 32'd1, "R8");
        look(10, 0, 32'd3, "R5");
        look(6, 0, 32'd4, "R8");

        // write-after-write in both completion orders
        issue(O_MUL, 11, 4, 5, 32'd0, c1);  push(7, 32'd35, c1 + 11, "R5");
        issue(O_ADD, 11, 4, 5, 32'd0, c2);  push(4, 32'd12, c1 + 4, "R5");
        look(11, 4, 32'd0, "R7");
        issue(O_LD, 12, 0, 0, 32'd50, c3);  push(1, 32'd50, c1 + 5, "R7");
        issue(O_MUL, 12, 5, 5, 32'd0, c4);  push(8, 32'd49, c1 + 14, "R5");
        probe(O_MUL, 1'b0, "R2");
        idle(2);
        look(12, 8, 32'd0, "R7");
        look(11, 0, 32'd12, "R8");
        idle(12);
        look(11, 0, 32'd12, "R7");
        look(12, 0, 32'd49, "R8");

        // bus contention: a load and two woken adders ready together
        issue(O_LD, 13, 0, 0, 32'd9, c1);   push(1, 32'd9, c1 + 3, "R4");
        issue(O_ADD, 14, 13, 4, 32'd0, c2); push(4, 32'd14, c1 + 7, "R9");
        issue(O_SUB, 15, 13, 5, 32'd0, c3); push(5, 32'd2, c1 + 8, "R9");
        issue(O_LD, 7, 0, 0, 32'd77, c4);   push(2, 32'd77, c1 + 6, "R9");
        idle(10);
        look(14, 0, 32'd14, "R9");
        look(15, 0, 32'd2, "R9");
        look(7, 0, 32'd77, "R8");

        // arithmetic corners
        issue(O_LD, 12, 0, 0, 32'h0001_0001, c1); push(1, 32'h0001_0001, c1 + 3, "R4");
        issue(O_DIV, 1, 4, 9, 32'd0, c2);   push(7, 32'hFFFF_FFFF, c2 + 41, "R10");
        issue(O_SUB, 2, 5, 3, 32'd0, c3);   push(4, 32'hFFFF_FFA3, c3 + 3, "R10");
        issue(O_MUL, 13, 12, 12, 32'd0, c4); push(8, 32'h0002_0001, c4 + 11, "R12");
        idle(50);
        look(1, 0, 32'hFFFF_FFFF, "R10");
        look(2, 0, 32'hFFFF_FFA3, "R10");
        look(13, 0, 32'h0002_0001, "R10");

        // every expected broadcast must have been seen
        foreach (sb[i]) chk(1'b0, sb[i].req, "missing broadcast tag", longint'(sb[i].tag), longint'(sb[i].at));
        chk(sb.size() == 0, "R9", "scoreboard drained", longint'(sb.size()), 0);

        summary();
        $finish;
    end

endmodule